// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives a serial bit clock from its parent clock through two division stages in series. The first stage is a linear prescaler that divides by any value from 1 to 32. The second stage divides by a power of two, from 1 up to 32. A requested total ratio arrives on an input together with a load strobe. A selection unit then turns that ratio into the two stage settings. It tries the power-of-two stage from the smallest value upward and stops at the first one whose rounded-up prescale is no more than 32.

The chosen settings appear on output ports. The divider runs with a period equal to their product. It provides a one-cycle clock enable per period and a divided clock level. A new setting never cuts a period short. The running period always finishes at its old length, and the new length starts on the next boundary, so the divided clock has no runt pulse.

Top module: `ser_clk_div`

## Requirements
- R1: On a load, the power-of-two setting is the smallest exponent e in 0..5 for which ceil(R/2^e) <= 32, and the prescale setting is that ceil(R/2^e). The power-of-two port carries e, so the stage divides by 2^e. The prescale port carries the division value 1..32 directly.
- R2: A requested ratio of zero is treated as 1024, which gives prescale 32 and exponent 5.
- R3: A requested ratio above 1024 gives exponent 5 with the prescale clamped to 32.
- R4: The settings ports change on the clock edge that samples the load strobe high. They hold their value while the strobe is low.
- R5: Once a setting is active, clk_en is a single-cycle pulse once every prescale * 2^exponent parent cycles.
- R6: In each period, div_clk is high for the first floor(total/2) cycles after the clk_en cycle and low for the rest.
- R7: A load made in the middle of a period does not change that period's length. The new total applies from the period that starts after the next clk_en pulse.
- R8: With a total of 1, clk_en is high on every parent cycle and div_clk stays low.
- R9: After reset, prescale is 1 and exponent is 0, so clk_en is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | parent clock |
| rst_n | input | 1 | asynchronous active-low reset |
| load | input | 1 | strobe that samples req_ratio |
| req_ratio | input | 11 | requested total division ratio, 0 meaning 1024 |
| pre_set | output | 6 | chosen linear prescale value, 1..32 |
| pow_set | output | 3 | chosen power-of-two exponent, 0..5 |
| clk_en | output | 1 | one-cycle pulse on the last cycle of each period |
| div_clk | output | 1 | divided clock level |

## Verification
The bench targets the ratios where the search moves to the next stage: 32/33, 64/65 and 1024/1025. It also covers zero, one, and a ratio above the maximum. A wrong rounding or an off-by-one bound in the search would report the wrong exponent here, or a prescale of 33. Odd totals check the duty rule; a wrong rounding shows up as one extra high cycle. A load in the middle of a long period checks that the running period still ends at its old length. A divider that restarts at once would end that period early.

// File: rtl/scd_pkg.sv
package scd_pkg;
  // fixed geometry of the two stages
  localparam int PRE_MAX = 32;
  localparam int POW_N   = 6;
endpackage

// File: rtl/scd_select.sv
module scd_select #(
  parameter int RATIO_W = 11,
  parameter int PRE_W   = 6,
  parameter int POW_W   = 3,
  parameter int POW_N   = scd_pkg::POW_N,
  parameter int PRE_MAX = scd_pkg::PRE_MAX
) (
  input  logic [RATIO_W-1:0] req,
  output logic [PRE_W-1:0]   pre,
  output logic [POW_W-1:0]   pow
);
  localparam int CW = RATIO_W + 1;
  localparam logic [RATIO_W-1:0] MAX_RATIO = RATIO_W'(PRE_MAX << (POW_N - 1));

  logic [RATIO_W-1:0] eff;
  logic [CW-1:0]      cand [POW_N];
  logic [POW_N-1:0]   fits;

  assign eff = (req == '0) ? MAX_RATIO : req;

  // one rounded-up prescale candidate per power-of-two step
  for (genvar k = 0; k < POW_N; k++) begin : g_step
    assign cand[k] = ({1'b0, eff} + CW'((1 << k) - 1)) >> k;
    assign fits[k] = (cand[k] <= CW'(PRE_MAX));
  end

  always_comb begin
    logic found;
    found = 1'b0;
    pow   = POW_W'(POW_N - 1);
    pre   = PRE_W'(PRE_MAX);
    for (int k = 0; k < POW_N; k++) begin
      if (fits[k] && !found) begin
        found = 1'b1;
        pow   = POW_W'(k);
        pre   = PRE_W'(cand[k]);
      end
    end
  end
endmodule

// File: rtl/scd_period.sv
module scd_period #(
  parameter int TOT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TOT_W-1:0] stage_total,
  output logic             clk_en,
  output logic             div_clk
);
  logic [TOT_W-1:0] cnt_q, cnt_d;
  logic [TOT_W-1:0] act_q, act_d;
  logic             boundary;

  assign boundary = (cnt_q == act_q - TOT_W'(1));

  always_comb begin
    cnt_d = boundary ? '0 : cnt_q + TOT_W'(1);
    act_d = boundary ? stage_total : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= TOT_W'(1);
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign clk_en  = boundary;
  assign div_clk = (cnt_q < (act_q >> 1));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < act_q);                                           // R5
  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(act_q));                              // R7
  AST_UNIT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == TOT_W'(1)) |-> (clk_en && !div_clk));           // R8
endmodule

// File: rtl/ser_clk_div.sv
module ser_clk_div #(
  parameter int RATIO_W = 11,
  parameter int PRE_W   = 6,
  parameter int POW_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [RATIO_W-1:0] req_ratio,
  output logic [PRE_W-1:0]   pre_set,
  output logic [POW_W-1:0]   pow_set,
  output logic               clk_en,
  output logic               div_clk
);
  localparam int POW_N   = scd_pkg::POW_N;
  localparam int PRE_MAX = scd_pkg::PRE_MAX;
  localparam int TOT_W   = $clog2(PRE_MAX) + POW_N;

  logic [PRE_W-1:0] pre_c, pre_q, pre_d;
  logic [POW_W-1:0] pow_c, pow_q, pow_d;
  logic [TOT_W-1:0] stage_total;

  scd_select #(
    .RATIO_W(RATIO_W), .PRE_W(PRE_W), .POW_W(POW_W),
    .POW_N(POW_N), .PRE_MAX(PRE_MAX)
  ) i_sel (
    .req(req_ratio),
    .pre(pre_c),
    .pow(pow_c)
  );

  always_comb begin
    pre_d = load ? pre_c : pre_q;
    pow_d = load ? pow_c : pow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= PRE_W'(1);
      pow_q <= '0;
    end else begin
      pre_q <= pre_d;
      pow_q <= pow_d;
    end
  end

  assign stage_total = TOT_W'(pre_q) << pow_q;
  assign pre_set     = pre_q;
  assign pow_set     = pow_q;

  scd_period #(.TOT_W(TOT_W)) i_per (
    .clk(clk),
    .rst_n(rst_n),
    .stage_total(stage_total),
    .clk_en(clk_en),
    .div_clk(div_clk)
  );

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q >= PRE_W'(1)) && (pre_q <= PRE_W'(PRE_MAX)));      // R1
  AST_POW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pow_q <= POW_W'(POW_N - 1));                              // R1
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(pre_q) && $stable(pow_q)));            // R4
  AST_OVER_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (req_ratio > RATIO_W'(PRE_MAX << (POW_N - 1))))
      |=> (pow_q == POW_W'(POW_N - 1) && pre_q == PRE_W'(PRE_MAX))); // R3
endmodule

// File: tb/test_ser_clk_div.sv
module test_ser_clk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [10:0] req_ratio = '0;
  logic [5:0]  pre_set;
  logic [2:0]  pow_set;
  logic        clk_en;
  logic        div_clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ser_clk_div i_ser_clk_div (
    .clk(clk), .rst_n(rst_n), .load(load), .req_ratio(req_ratio),
    .pre_set(pre_set), .pow_set(pow_set), .clk_en(clk_en), .div_clk(div_clk)
  );

  function automatic int exp_pre(int r);
    int e = (r == 0) ? 1024 : r;
    for (int k = 0; k < 6; k++) begin
      int d = 1 << k;
      if ((e + d - 1) / d <= 32) return (e + d - 1) / d;
    end
    return 32;
  endfunction

  function automatic int exp_pow(int r);
    int e = (r == 0) ? 1024 : r;
    for (int k = 0; k < 6; k++) begin
      int d = 1 << k;
      if ((e + d - 1) / d <= 32) return k;
    end
    return 5;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sync_en();
    int guard = 0;
    @(negedge clk);
    while (!clk_en && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // count cycles and high cycles from one clk_en to the next
  task automatic count_period(output int n, output int hi);
    n = 0; hi = 0;
    do begin
      @(negedge clk);
      n++;
      if (div_clk) hi++;
    end while (!clk_en && n < 5000);
  endtask

  task automatic apply(int r, string req);
    int n, hi, t;
    @(negedge clk);
    req_ratio = 11'(r);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check({req, " pre"}, int'(pre_set), exp_pre(r));
    check({req, " pow"}, int'(pow_set), exp_pow(r));
    t = exp_pre(r) << exp_pow(r);
    sync_en();
    count_period(n, hi);
    check({req, " R5 period"}, n, t);
    check({req, " R6 high"}, hi, t / 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, hi;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    @(negedge clk);
    check("R9 pre", int'(pre_set), 1);
    check("R9 pow", int'(pow_set), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9 en", int'(clk_en), 1);
    end
    // R8 unit ratio
    apply(1, "R8");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 en", int'(clk_en), 1);
      check("R8 clk", int'(div_clk), 0);
    end
    // R1 stage edges
    apply(32, "R1 32");
    apply(33, "R1 33");
    apply(64, "R1 64");
    apply(65, "R1 65");
    apply(7, "R1 7");
    apply(1024, "R1 1024");
    // R2 zero
    apply(0, "R2");
    check("R2 pre", int'(pre_set), 32);
    check("R2 pow", int'(pow_set), 5);
    // R3 over range
    apply(1025, "R3 1025");
    apply(2000, "R3");
    check("R3 pre", int'(pre_set), 32);
    check("R3 pow", int'(pow_set), 5);
    // R4 hold while strobe low
    @(negedge clk);
    req_ratio = 11'd3;
    repeat (3) @(negedge clk);
    check("R4 pre hold", int'(pre_set), 32);
    check("R4 pow hold", int'(pow_set), 5);
    // R7 load mid-period
    apply(20, "R7 setup");
    sync_en();
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 3) begin req_ratio = 11'd6; load = 1'b1; end
      if (n == 4) load = 1'b0;
    end while (!clk_en && n < 5000);
    check("R7 old period", n, 20);
    count_period(n, hi);
    check("R7 new period", n, 6);
    check("R7 new high", hi, 3);
    // random ratios
    for (int i = 0; i < 25; i++) begin
      apply(int'($urandom_range(1, 300)), "R1 R5 R6 rand");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule